// File: doc/BRIEF.md
# PoE classification event decoder

This block sits in the digital part of a powered-device interface and works out how much power the power source has granted. It does not see the port voltage itself. Comparators elsewhere report, as single-bit flags, whether the port is in the classification range, in the mark range, below the reset threshold, or switched on. The block counts how many times the source steps the port from the classification range back to the mark range before power-on. It also times the first classification step, because a first step that is held long marks a source of the extended-power kind.

Once power-good is valid, the block drives one open-drain type-indicator pin. Depending on the allocation, the pin is released (high impedance), held constantly low, or pulsed low for a set fraction of a fixed period. A supply flag for auxiliary power takes precedence over all of this. While it is set, the pin reports full power for the configured class group.

All range flags pass through a two-flop synchronizer and a debounce filter before they are used. The pulse period and the extended-source timing window are counts of system-clock cycles, set by parameters.

Top module: `poe_evt_decoder`

## Requirements
- R1: After reset, `pull_o` is 0. Throughout this block, `pull_o` = 1 means the pin is low impedance and 0 means it is released.
- R2: When `aux_i` is 0 and `pgood_i` is 0, `pull_o` is 0 in the following cycle, whatever the event count is.
- R3: One event is a filtered classification-range flag followed by a filtered mark-range flag. With `pgood_i` = 1, `aux_i` = 0 and an event count of 0 or 1, the pin stays released.
- R4: With `pgood_i` = 1 and `aux_i` = 0, the pin is held constantly low in two cases: after two events, or after three events from a standard source.
- R5: When the first classification excursion lasts at least `EXT_CYC` cycles, the source is marked extended-power. Three events from such a source give a pin that is low for 3/4 of each period.
- R6: Four events give a pin that is low for 1/2 of each period. Five events give a pin that is low for 1/4 of each period.
- R7: The event count never exceeds five. Any classification event after the fifth leaves the output unchanged.
- R8: A filtered below-reset flag clears the event count and the source-type decision.
- R9: `aux_i` = 1 overrides the event count and `pgood_i`. With `hi_class_i` = 0 (requested class 0 to 4) the pin is held constantly low. With `hi_class_i` = 1 (class 5 to 8) it is low for 3/4 of each period.
- R10: A range-flag pulse shorter than `DEB_CYC` cycles is ignored and does not form part of an event.
- R11: The duty-cycle codes repeat every `PERIOD_CYC` cycles. Over any window of `PERIOD_CYC` cycles, the number of low cycles equals the code's fraction of `PERIOD_CYC`.
- R12: While the filtered power-on flag is set, classification excursions are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cls_rng_i | input | 1 | Port voltage is in the classification range (asynchronous) |
| mrk_rng_i | input | 1 | Port voltage is in the mark range (asynchronous) |
| below_rst_i | input | 1 | Port voltage is below the reset threshold (asynchronous) |
| pwr_on_i | input | 1 | Port voltage is above the power-on threshold (asynchronous) |
| pgood_i | input | 1 | Power-good is valid (synchronous) |
| aux_i | input | 1 | Auxiliary supply is present (synchronous) |
| hi_class_i | input | 1 | Requested class is in group 5 to 8 (synchronous) |
| pull_o | output | 1 | 1 = type-indicator pin is low impedance |

## Verification
If the event counter or the source-type flag holds a wrong value, the port shows the wrong duty code one cycle after the allocation is read. That code is visible as a different number of low cycles in a single period window.

A filter that lets a short glitch through, or a counter that does not saturate, adds one event. That extra event moves the code by one step, for example from released to constantly low, or from 1/2 to 1/4. A clear on below-reset that is missing leaves the previous allocation visible in the next scenario.

// File: rtl/poe_evt_pkg.sv
package poe_evt_pkg;

    typedef enum logic [2:0] {
        TC_HIZ,
        TC_LOW,
        TC_D75,
        TC_D50,
        TC_D25
    } tcode_e;

    typedef enum logic [1:0] {
        PH_WAIT,
        PH_CLASS,
        PH_MARK
    } phase_e;

    localparam int unsigned CNT_W   = 3;
    localparam int unsigned EVT_MAX = 5;

    function automatic tcode_e pick_code(
        input logic             aux,
        input logic             hi,
        input logic             pg,
        input logic [CNT_W-1:0] n,
        input logic             ext
    );
        tcode_e c;
        if (aux) begin
            c = hi ? TC_D75 : TC_LOW;
        end else if (!pg) begin
            c = TC_HIZ;
        end else begin
            case (n)
                3'd2:    c = TC_LOW;
                3'd3:    c = ext ? TC_D75 : TC_LOW;
                3'd4:    c = TC_D50;
                3'd5:    c = TC_D25;
                default: c = TC_HIZ;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/poe_flag_filter.sv
module poe_flag_filter #(
    parameter int unsigned DEB_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic flt_o
);
    localparam int unsigned DW = (DEB_CYC < 2) ? 1 : $clog2(DEB_CYC);

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic          stable;
        logic [DW-1:0] cnt;
    } flt_st_t;

    flt_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = raw_i;
        st_d.s2 = st_q.s1;
        if (st_q.s2 == st_q.stable) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == DW'(DEB_CYC - 1)) begin
            st_d.stable = st_q.s2;
            st_d.cnt    = '0;
        end else begin
            st_d.cnt = st_q.cnt + DW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flt_o = st_q.stable;

endmodule

// File: rtl/poe_evt_counter.sv
module poe_evt_counter
    import poe_evt_pkg::*;
#(
    parameter int unsigned EXT_CYC = 17_400_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cls_i,
    input  logic             mrk_i,
    input  logic             brst_i,
    input  logic             pwr_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ext_o
);
    localparam int unsigned TW = $clog2(EXT_CYC + 1);

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
        logic             ext;
        logic [TW-1:0]    tmr;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (brst_i) begin
            st_d = '{phase: PH_WAIT, cnt: '0, ext: 1'b0, tmr: '0};
        end else if (!pwr_i) begin
            case (st_q.phase)
                PH_WAIT, PH_MARK: begin
                    if (cls_i) begin
                        st_d.phase = PH_CLASS;
                        st_d.tmr   = '0;
                    end
                end
                PH_CLASS: begin
                    if (mrk_i && !cls_i) begin
                        st_d.phase = PH_MARK;
                        if (st_q.cnt == CNT_W'(0)) begin
                            st_d.ext = (st_q.tmr >= TW'(EXT_CYC));
                        end
                        if (st_q.cnt < CNT_W'(EVT_MAX)) begin
                            st_d.cnt = st_q.cnt + CNT_W'(1);
                        end
                    end else if (st_q.tmr < TW'(EXT_CYC)) begin
                        st_d.tmr = st_q.tmr + TW'(1);
                    end
                end
                default: st_d.phase = PH_WAIT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_WAIT, cnt: '0, ext: 1'b0, tmr: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;
    assign ext_o = st_q.ext;

endmodule

// File: rtl/poe_t2p_pwm.sv
module poe_t2p_pwm
    import poe_evt_pkg::*;
#(
    parameter int unsigned PERIOD_CYC = 200_000
) (
    input  logic   clk,
    input  logic   rst_n,
    input  tcode_e code_i,
    output logic   pull_o
);
    localparam int unsigned PW    = $clog2(PERIOD_CYC);
    localparam int unsigned THR75 = (PERIOD_CYC * 3) / 4;
    localparam int unsigned THR50 = PERIOD_CYC / 2;
    localparam int unsigned THR25 = PERIOD_CYC / 4;

    typedef struct packed {
        logic [PW-1:0] ph;
        logic          pull;
    } pwm_st_t;

    pwm_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.ph = (st_q.ph == PW'(PERIOD_CYC - 1)) ? '0 : st_q.ph + PW'(1);
        case (code_i)
            TC_LOW:  st_d.pull = 1'b1;
            TC_D75:  st_d.pull = (st_q.ph < PW'(THR75));
            TC_D50:  st_d.pull = (st_q.ph < PW'(THR50));
            TC_D25:  st_d.pull = (st_q.ph < PW'(THR25));
            default: st_d.pull = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pull_o = st_q.pull;

endmodule

// File: rtl/poe_evt_decoder.sv
module poe_evt_decoder
    import poe_evt_pkg::*;
#(
    parameter int unsigned DEB_CYC    = 8,
    parameter int unsigned EXT_CYC    = 17_400_000,
    parameter int unsigned PERIOD_CYC = 200_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cls_rng_i,
    input  logic mrk_rng_i,
    input  logic below_rst_i,
    input  logic pwr_on_i,
    input  logic pgood_i,
    input  logic aux_i,
    input  logic hi_class_i,
    output logic pull_o
);
    localparam int unsigned NFLAG = 4;

    logic [NFLAG-1:0] raw_flags;
    logic [NFLAG-1:0] flt;
    logic [CNT_W-1:0] evt_cnt;
    logic             ext_src;
    tcode_e           code;

    assign raw_flags = {pwr_on_i, below_rst_i, mrk_rng_i, cls_rng_i};

    for (genvar g = 0; g < NFLAG; g++) begin : g_flt
        poe_flag_filter #(.DEB_CYC(DEB_CYC)) u_flt (
            .clk   (clk),
            .rst_n (rst_n),
            .raw_i (raw_flags[g]),
            .flt_o (flt[g])
        );
    end

    poe_evt_counter #(.EXT_CYC(EXT_CYC)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .cls_i  (flt[0]),
        .mrk_i  (flt[1]),
        .brst_i (flt[2]),
        .pwr_i  (flt[3]),
        .cnt_o  (evt_cnt),
        .ext_o  (ext_src)
    );

    always_comb begin
        code = pick_code(aux_i, hi_class_i, pgood_i, evt_cnt, ext_src);
    end

    poe_t2p_pwm #(.PERIOD_CYC(PERIOD_CYC)) u_pwm (
        .clk    (clk),
        .rst_n  (rst_n),
        .code_i (code),
        .pull_o (pull_o)
    );

endmodule

// File: rtl/poe_evt_chk.sv
module poe_evt_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       aux_i,
    input logic       hi_class_i,
    input logic       pgood_i,
    input logic       pull_o,
    input logic [2:0] cnt,
    input logic       ext,
    input logic       brst
);
    // R2
    released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!aux_i && !pgood_i) |=> !pull_o);

    // R9
    aux_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (aux_i && !hi_class_i) |=> pull_o);

    // R8
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brst |=> (cnt == 3'd0 && !ext));

    // R7
    cnt_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= 3'd5);

    // R7
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != $past(cnt)) |-> (cnt == $past(cnt) + 3'd1 || cnt == 3'd0));

    // R5
    ext_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ext) |-> cnt == 3'd1);
endmodule

bind poe_evt_decoder poe_evt_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .aux_i      (aux_i),
    .hi_class_i (hi_class_i),
    .pgood_i    (pgood_i),
    .pull_o     (pull_o),
    .cnt        (evt_cnt),
    .ext        (ext_src),
    .brst       (flt[2])
);

// File: tb/poe_evt_decoder_tb.sv
module poe_evt_decoder_tb_top;
    localparam int DEB = 3;
    localparam int EXT = 60;
    localparam int PER = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cls = 0, mrk = 0, brst = 0, pwr = 0, pg = 0, aux = 0, hi = 0;
    logic pull;
    int   n_tests = 0;
    int   n_fail = 0;
    bit   done = 0;

    always #2.5 clk = ~clk;

    poe_evt_decoder #(.DEB_CYC(DEB), .EXT_CYC(EXT), .PERIOD_CYC(PER)) dut_i (
        .clk(clk), .rst_n(rst_n), .cls_rng_i(cls), .mrk_rng_i(mrk),
        .below_rst_i(brst), .pwr_on_i(pwr), .pgood_i(pg), .aux_i(aux),
        .hi_class_i(hi), .pull_o(pull)
    );

    function automatic int exp_lows(int n, bit ext, bit a, bit h, bit p);
        int k;
        k = (n > 5) ? 5 : n;
        if (a) return h ? (PER * 3) / 4 : PER;
        if (!p) return 0;
        case (k)
            2: return PER;
            3: return ext ? (PER * 3) / 4 : PER;
            4: return PER / 2;
            5: return PER / 4;
            default: return 0;
        endcase
    endfunction

    task automatic idle(int c);
        repeat (c) @(negedge clk);
    endtask

    task automatic one_event(int len);
        cls = 1; mrk = 0; idle(len);
        cls = 0; mrk = 1; idle(20);
    endtask

    task automatic measure(output int lows);
        lows = 0;
        for (int i = 0; i < PER; i++) begin
            @(negedge clk);
            if (pull) lows++;
        end
    endtask

    task automatic check(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: low cycles %0d, expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_port();
        pg = 0; aux = 0; pwr = 0; mrk = 0; cls = 0;
        brst = 1; idle(12);
        brst = 0; idle(12);
    endtask

    task automatic scenario(string req, int n, bit ext, bit a, bit h);
        int lows;
        for (int i = 0; i < n; i++) one_event((i == 0 && ext) ? 120 : 20);
        pwr = 1; idle(12);
        pg = 1; aux = a; hi = h; idle(12);
        measure(lows);
        check(req, lows, exp_lows(n, ext, a, h, 1'b1));
        clear_port();
    endtask

    initial begin
        int lows;
        idle(3);
        // R1 reset state
        n_tests++;
        if (pull !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: pull %b, expected 0", pull);
        end
        rst_n = 1; idle(5);

        scenario("R3 one event", 1, 0, 0, 0);
        scenario("R3 no events", 0, 0, 0, 0);
        scenario("R4 two events", 2, 0, 0, 0);
        scenario("R4 three standard", 3, 0, 0, 0);
        scenario("R5 three extended", 3, 1, 0, 0);
        scenario("R6 four events", 4, 0, 0, 0);
        scenario("R6 five events", 5, 1, 0, 0);
        scenario("R7 seven events", 7, 0, 0, 0);
        scenario("R9 aux low group", 4, 0, 1, 0);
        scenario("R9 aux high group", 1, 0, 1, 1);
        scenario("R11 extended four", 4, 1, 0, 0);

        // R2: events present but power-good low
        for (int i = 0; i < 4; i++) one_event(20);
        pwr = 1; idle(12);
        measure(lows);
        check("R2 pgood low", lows, 0);
        // R12: excursion while powered not counted
        one_event(20);
        pg = 1; idle(12);
        measure(lows);
        check("R12 powered excursion", lows, PER / 2);
        // R9 aux overrides pgood low
        pg = 0; aux = 1; hi = 1; idle(6);
        measure(lows);
        check("R9 aux over pgood", lows, (PER * 3) / 4);
        clear_port();

        // R8: clear after three extended events
        for (int i = 0; i < 3; i++) one_event(i == 0 ? 120 : 20);
        clear_port();
        one_event(20); one_event(20);
        pwr = 1; idle(12); pg = 1; idle(12);
        measure(lows);
        check("R8 cleared count", lows, PER);
        clear_port();

        // R10: short class glitch ignored
        one_event(20);
        cls = 1; idle(DEB - 1); cls = 0; mrk = 1; idle(20);
        pwr = 1; idle(12); pg = 1; idle(12);
        measure(lows);
        check("R10 glitch ignored", lows, 0);
        clear_port();

        // Random mix
        void'($urandom(32'd4293));
        for (int t = 0; t < 30; t++) begin
            int n;
            bit e, a, h;
            n = $urandom_range(0, 7);
            e = $urandom_range(0, 1);
            a = ($urandom_range(0, 3) == 0);
            h = $urandom_range(0, 1);
            if (n == 0) e = 0;
            scenario("R6 random", n, e, a, h);
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule